// File: doc/BRIEF.md
# Two-Rank Pattern Store for a Binary Correlator

This block keeps the reference bit pattern and the tap-enable mask for a 256-tap binary correlator. Each pattern lives in two ranks. A staging rank is filled by the host while the correlator keeps running. An active rank drives the correlation array. A single clock-synchronous transfer copies the staging rank into the active rank. Reference bytes arrive on a dedicated byte bus with an active-high load strobe. Mask bytes and the small configuration words arrive on a shared control byte bus. That bus has a 3-bit register select and an active-low load strobe.

Both load strobes are asynchronous to the system clock. Each one is passed through a two-flop synchroniser and edge-detected before it writes anything. A write therefore lands on the third rising clock edge after the strobe's active edge, and the host must hold the bus for at least four clock periods after that edge. The window code sets how each byte is split across the eight 32-bit stages. With code c the stages form 2^c lanes. Lane j takes its new bit from bus bit 7-j and shifts that bit along its own stages. Code 0 is a single 256-bit serial line. Code 3 gives eight independent 32-bit stages.

Top module: `refmask_loader`

## Requirements
- R1: After reset both active ranks, both staging ranks, the window code, the 9-bit score offset and the output delay are all zero.
- R2: One rising edge of the reference load strobe shifts the reference staging rank exactly once, however long the strobe stays high. The byte is taken on the third rising clock edge after the strobe edge.
- R3: With window code 0, each reference load shifts the whole 256-bit rank by one position toward higher indices. Bus bit 7 enters at index 0, and bus bits 6..0 are ignored.
- R4: With window code 3, each stage s (bits 32s+31..32s) shifts on its own. Bus bit 7-s enters at bit 32s.
- R5: With window code 1 or 2, the rank splits into 2 or 4 equal lanes. Lane j shifts within its own bits and takes bus bit 7-j at its lowest index.
- R6: The active ranks change only on a rising clock edge with xfer_n low. They then take the staging contents.
- R7: When a transfer and a load write fall on the same clock edge, the transfer copies the staging contents as they stood before that load.
- R8: Writing the window code changes neither the staged nor the active reference contents.
- R9: The control load strobe is active low, and a write takes effect on its rising edge. Select 0 sets the window code from bits 1..0. Select 2 sets offset bits 7..0, and select 3 sets offset bit 8 from bus bit 0. Select 4 sets the 8-bit output delay.
- R10: Select 1 shifts a mask byte into the mask staging rank, using the same lane pattern as the reference rank. A transfer then moves it into the active mask rank. The reference ranks are untouched.
- R11: Control writes with select 5, 6 or 7 change no output and no stored mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_byte | input | 8 | Reference byte bus |
| ref_strobe | input | 1 | Reference load strobe, acts on its rising edge |
| ctl_byte | input | 8 | Control byte bus (mask and configuration) |
| ctl_sel | input | 3 | Control register select |
| ctl_strobe_n | input | 1 | Control load strobe, active low, acts on its rising edge |
| xfer_n | input | 1 | Transfer enable, active low, sampled on clk |
| act_ref | output | 256 | Active reference rank |
| act_mask | output | 256 | Active mask rank |
| win_code | output | 2 | Window code (log2 of lane count) |
| score_ofs | output | 9 | Score offset |
| out_delay | output | 8 | Output delay setting |

## Verification
The bench uses the default parameters: eight 32-bit stages, a 9-bit offset and an 8-bit delay. With these values the offset is split across two control selects and every one of the four window codes is reachable. The 256-bit ranks are short enough that a full serial load stays within the run budget. Lane boundaries at 32, 64 and 128 bits are covered by loading in each code and then comparing whole ranks. Synchroniser latency is exercised by a held strobe and by a transfer placed exactly on the write edge.

// File: rtl/refmask_pkg.sv
`timescale 1ns/1ps
package refmask_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    CS_WIN    = 3'd0,
    CS_MASK   = 3'd1,
    CS_OFS_LO = 3'd2,
    CS_OFS_HI = 3'd3,
    CS_DELAY  = 3'd4,
    CS_RSV5   = 3'd5,
    CS_RSV6   = 3'd6,
    CS_RSV7   = 3'd7
  } ctl_sel_e;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser plus edge detector; flags the rising edge of the strobe.
module strobe_sync #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  output logic rise_o
);
  logic [2:0] sync_q;
  logic [2:0] sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], strb_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {3{IDLE}};
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ctl_decode.sv
`timescale 1ns/1ps
module ctl_decode
  import refmask_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned OFS_W  = 9,
  parameter int unsigned DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic              mask_shift_o,
  output logic [MODE_W-1:0] win_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [DLY_W-1:0]  dly_o
);
  localparam int unsigned HI_W = OFS_W - BUS_W;

  logic [MODE_W-1:0] win_q, win_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  ctl_sel_e          sel;

  assign sel = ctl_sel_e'(sel_i);

  always_comb begin
    win_d        = win_q;
    ofs_d        = ofs_q;
    dly_d        = dly_q;
    mask_shift_o = 1'b0;
    if (evt_i) begin
      case (sel)
        CS_WIN:    win_d = data_i[MODE_W-1:0];
        CS_MASK:   mask_shift_o = 1'b1;
        CS_OFS_LO: ofs_d[BUS_W-1:0] = data_i;
        CS_OFS_HI: ofs_d[OFS_W-1:BUS_W] = data_i[HI_W-1:0];
        CS_DELAY:  dly_d = data_i[DLY_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      ofs_q <= '0;
      dly_q <= '0;
    end else begin
      win_q <= win_d;
      ofs_q <= ofs_d;
      dly_q <= dly_d;
    end
  end

  assign win_o = win_q;
  assign ofs_o = ofs_q;
  assign dly_o = dly_q;
endmodule

// File: rtl/shift_rank.sv
`timescale 1ns/1ps
// Staging rank of N_ST stages, chained into 2^mode lanes, plus active rank.
module shift_rank #(
  parameter int unsigned N_ST   = 8,
  parameter int unsigned ST_LEN = 32,
  parameter int unsigned MODE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [N_ST-1:0]        din_i,
  input  logic                   xfer_i,
  output logic [N_ST*ST_LEN-1:0] pre_o,
  output logic [N_ST*ST_LEN-1:0] act_o
);
  localparam int unsigned TOT = N_ST * ST_LEN;
  localparam int unsigned LG  = $clog2(N_ST);

  logic [TOT-1:0]  pre_q, pre_d;
  logic [TOT-1:0]  act_q, act_d;
  logic [N_ST-1:0] feed;

  for (genvar s = 0; s < N_ST; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign feed[s] = din_i[N_ST-1];
    end else begin : g_link
      localparam logic [2*LG-1:0] SIDX = (2*LG)'(s);
      logic [2*LG-1:0] scaled;
      logic [LG:0]     span_m1;
      logic [LG-1:0]   lane;
      logic            first;
      assign scaled  = SIDX << mode_i;
      assign lane    = scaled[2*LG-1:LG];
      assign span_m1 = ((LG+1)'(N_ST) >> mode_i) - (LG+1)'(1);
      assign first   = ((SIDX[LG:0] & span_m1) == '0);
      assign feed[s] = first ? din_i[(LG)'(N_ST-1) - lane] : pre_q[s*ST_LEN-1];
    end
    assign pre_d[s*ST_LEN +: ST_LEN] = shift_i ?
      {pre_q[s*ST_LEN +: ST_LEN-1], feed[s]} : pre_q[s*ST_LEN +: ST_LEN];
  end

  always_comb begin
    act_d = act_q;
    if (xfer_i) act_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;
endmodule

// File: rtl/refmask_loader.sv
`timescale 1ns/1ps
module refmask_loader
  import refmask_pkg::*;
#(
  parameter int unsigned N_STAGES  = 8,
  parameter int unsigned STAGE_LEN = 32,
  parameter int unsigned OFS_W     = 9,
  parameter int unsigned DLY_W     = 8,
  localparam int unsigned BUS_W    = N_STAGES,
  localparam int unsigned TAPS     = N_STAGES * STAGE_LEN,
  localparam int unsigned MODE_W   = $clog2($clog2(N_STAGES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  ref_byte,
  input  logic              ref_strobe,
  input  logic [BUS_W-1:0]  ctl_byte,
  input  logic [SEL_W-1:0]  ctl_sel,
  input  logic              ctl_strobe_n,
  input  logic              xfer_n,
  output logic [TAPS-1:0]   act_ref,
  output logic [TAPS-1:0]   act_mask,
  output logic [MODE_W-1:0] win_code,
  output logic [OFS_W-1:0]  score_ofs,
  output logic [DLY_W-1:0]  out_delay
);
  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic            ref_evt;
  logic            ctl_evt;
  logic            mask_shift;
  logic            xfer;
  logic [TAPS-1:0] pre_ref;
  logic [TAPS-1:0] pre_mask;

  // reset asserts asynchronously and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign xfer = ~xfer_n;

  strobe_sync #(.IDLE(1'b0)) u_ref_sync (
    .clk(clk), .rst_n(rst_int_n), .strb_i(ref_strobe), .rise_o(ref_evt)
  );

  strobe_sync #(.IDLE(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_int_n), .strb_i(ctl_strobe_n), .rise_o(ctl_evt)
  );

  ctl_decode #(
    .BUS_W(BUS_W), .MODE_W(MODE_W), .OFS_W(OFS_W), .DLY_W(DLY_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_int_n), .evt_i(ctl_evt), .sel_i(ctl_sel),
    .data_i(ctl_byte), .mask_shift_o(mask_shift), .win_o(win_code),
    .ofs_o(score_ofs), .dly_o(out_delay)
  );

  shift_rank #(.N_ST(N_STAGES), .ST_LEN(STAGE_LEN), .MODE_W(MODE_W)) u_ref (
    .clk(clk), .rst_n(rst_int_n), .shift_i(ref_evt), .mode_i(win_code),
    .din_i(ref_byte), .xfer_i(xfer), .pre_o(pre_ref), .act_o(act_ref)
  );

  shift_rank #(.N_ST(N_STAGES), .ST_LEN(STAGE_LEN), .MODE_W(MODE_W)) u_mask (
    .clk(clk), .rst_n(rst_int_n), .shift_i(mask_shift), .mode_i(win_code),
    .din_i(ctl_byte), .xfer_i(xfer), .pre_o(pre_mask), .act_o(act_mask)
  );
endmodule

// File: rtl/refmask_chk.sv
`timescale 1ns/1ps
module refmask_chk #(
  parameter int unsigned TAPS   = 256,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned OFS_W  = 9,
  parameter int unsigned DLY_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_n,
  input logic              ref_strobe,
  input logic              ref_evt,
  input logic              ctl_evt,
  input logic [TAPS-1:0]   pre_ref,
  input logic [TAPS-1:0]   pre_mask,
  input logic [TAPS-1:0]   act_ref,
  input logic [TAPS-1:0]   act_mask,
  input logic [MODE_W-1:0] win_code,
  input logic [OFS_W-1:0]  score_ofs,
  input logic [DLY_W-1:0]  out_delay
);
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_n |=> ($stable(act_ref) && $stable(act_mask))); // R6

  AST_XFER_OLD_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_n |=> (act_ref == $past(pre_ref) && act_mask == $past(pre_mask))); // R7

  AST_REF_ONE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |=> !ref_evt); // R2

  AST_REF_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |-> $past(ref_strobe, 2)); // R2

  AST_PRE_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_evt |=> $stable(pre_ref)); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_evt |=> ($stable(win_code) && $stable(score_ofs) &&
                  $stable(out_delay) && $stable(pre_mask))); // R11
endmodule

bind refmask_loader refmask_chk #(
  .TAPS(TAPS), .MODE_W(MODE_W), .OFS_W(OFS_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .ref_strobe(ref_strobe),
  .ref_evt(ref_evt), .ctl_evt(ctl_evt), .pre_ref(pre_ref), .pre_mask(pre_mask),
  .act_ref(act_ref), .act_mask(act_mask), .win_code(win_code),
  .score_ofs(score_ofs), .out_delay(out_delay)
);

// File: tb/tb_refmask_loader.sv
`timescale 1ns/1ps
module tb_refmask_loader;
  localparam int TAPS = 256;
  localparam int NV   = 10;

  // {sel[3], data[8], win[2], ofs[9], dly[8]}
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 8'h03, 2'd3, 9'h000, 8'h00},
    {3'd2, 8'hA5, 2'd3, 9'h0A5, 8'h00},
    {3'd3, 8'h01, 2'd3, 9'h1A5, 8'h00},
    {3'd4, 8'h3C, 2'd3, 9'h1A5, 8'h3C},
    {3'd5, 8'hFF, 2'd3, 9'h1A5, 8'h3C},
    {3'd6, 8'h12, 2'd3, 9'h1A5, 8'h3C},
    {3'd7, 8'h00, 2'd3, 9'h1A5, 8'h3C},
    {3'd3, 8'hFE, 2'd3, 9'h0A5, 8'h3C},
    {3'd0, 8'hFD, 2'd1, 9'h0A5, 8'h3C},
    {3'd0, 8'h00, 2'd0, 9'h0A5, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] ref_byte, ctl_byte;
  logic [2:0] ctl_sel;
  logic ref_strobe, ctl_strobe_n, xfer_n;
  logic [TAPS-1:0] act_ref, act_mask;
  logic [1:0] win_code;
  logic [8:0] score_ofs;
  logic [7:0] out_delay;

  int n_cmp = 0;
  int n_bad = 0;
  int mode = 0;
  logic [TAPS-1:0] m_ref = '0;
  logic [TAPS-1:0] m_mask = '0;
  logic [TAPS-1:0] snap;

  always #4 clk = ~clk;

  refmask_loader dut (
    .clk(clk), .rst_n(rst_n), .ref_byte(ref_byte), .ref_strobe(ref_strobe),
    .ctl_byte(ctl_byte), .ctl_sel(ctl_sel), .ctl_strobe_n(ctl_strobe_n),
    .xfer_n(xfer_n), .act_ref(act_ref), .act_mask(act_mask),
    .win_code(win_code), .score_ofs(score_ofs), .out_delay(out_delay)
  );

  function automatic logic [TAPS-1:0] lane_shift(input logic [TAPS-1:0] a,
                                                  input int code,
                                                  input logic [7:0] b);
    logic [TAPS-1:0] r;
    int k;
    int len;
    r   = a;
    k   = 1 << code;
    len = TAPS / k;
    for (int j = 0; j < k; j++) begin
      for (int i = j*len + len - 1; i > j*len; i--) r[i] = a[i-1];
      r[j*len] = b[7-j];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [TAPS-1:0] act,
                       input logic [TAPS-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ref_write(input logic [7:0] b);
    @(negedge clk); ref_byte = b; ref_strobe = 1'b1;
    @(negedge clk); ref_strobe = 1'b0;
    repeat (4) @(negedge clk);
    m_ref = lane_shift(m_ref, mode, b);
  endtask

  task automatic ctl_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); ctl_sel = sel; ctl_byte = d; ctl_strobe_n = 1'b0;
    @(negedge clk); ctl_strobe_n = 1'b1;
    repeat (4) @(negedge clk);
    if (sel == 3'd0) mode = int'(d[1:0]);
    if (sel == 3'd1) m_mask = lane_shift(m_mask, mode, d);
  endtask

  task automatic do_xfer();
    @(negedge clk); xfer_n = 1'b0;
    @(negedge clk); xfer_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_byte = '0; ref_strobe = 1'b0; ctl_byte = '0;
    ctl_sel = '0; ctl_strobe_n = 1'b1; xfer_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 act_ref", act_ref, '0);
    check("R1 act_mask", act_mask, '0);
    check("R1 cfg", TAPS'({win_code, score_ofs, out_delay}), '0);

    // R9 / R11 table walk of control writes
    for (int v = 0; v < NV; v++) begin
      ctl_write(VEC[v][29:27], VEC[v][26:19]);
      check((VEC[v][29:27] >= 3'd5) ? "R11 ignored select" : "R9 control write",
            TAPS'({win_code, score_ofs, out_delay}), TAPS'(VEC[v][18:0]));
    end
    do_xfer();
    check("R11 mask untouched", act_mask, m_mask);

    // R3 serial window
    for (int i = 0; i < 12; i++) ref_write(8'((i * 37) ^ 8'h5A));
    do_xfer();
    check("R3 serial load", act_ref, m_ref);

    // R8 window change keeps reference
    ctl_write(3'd0, 8'h03);
    do_xfer();
    check("R8 ref kept", act_ref, m_ref);

    // R4 parallel window
    for (int i = 0; i < 5; i++) ref_write(8'((i * 91) + 8'h13));
    do_xfer();
    check("R4 parallel load", act_ref, m_ref);

    // R5 intermediate windows
    ctl_write(3'd0, 8'h01);
    for (int i = 0; i < 3; i++) ref_write(8'((i * 29) ^ 8'hC3));
    do_xfer();
    check("R5 two lanes", act_ref, m_ref);
    ctl_write(3'd0, 8'h02);
    for (int i = 0; i < 3; i++) ref_write(8'((i * 53) ^ 8'h3E));
    do_xfer();
    check("R5 four lanes", act_ref, m_ref);

    // R2 held strobe shifts once
    @(negedge clk); ref_byte = 8'hB6; ref_strobe = 1'b1;
    repeat (3) @(negedge clk);
    ref_byte = 8'h49;
    repeat (7) @(negedge clk);
    ref_strobe = 1'b0;
    repeat (4) @(negedge clk);
    m_ref = lane_shift(m_ref, mode, 8'hB6);
    do_xfer();
    check("R2 single shift", act_ref, m_ref);

    // R6 no transfer, no change
    snap = m_ref;
    ref_write(8'hE7);
    repeat (3) @(negedge clk);
    check("R6 active holds", act_ref, snap);
    do_xfer();
    check("R6 transfer copies", act_ref, m_ref);

    // R7 transfer on the write edge takes the old contents
    snap = m_ref;
    @(negedge clk); ref_byte = 8'h9D; ref_strobe = 1'b1;
    @(negedge clk); ref_strobe = 1'b0;
    @(negedge clk); xfer_n = 1'b0;
    @(negedge clk); xfer_n = 1'b1;
    check("R7 old contents", act_ref, snap);
    repeat (2) @(negedge clk);
    m_ref = lane_shift(m_ref, mode, 8'h9D);
    do_xfer();
    check("R7 new after next", act_ref, m_ref);

    // R10 mask loading
    snap = m_ref;
    ctl_write(3'd0, 8'h03);
    for (int i = 0; i < 4; i++) ctl_write(3'd1, 8'((i * 71) ^ 8'h96));
    ctl_write(3'd0, 8'h00);
    for (int i = 0; i < 3; i++) ctl_write(3'd1, 8'((i * 17) + 8'h81));
    do_xfer();
    check("R10 mask rank", act_mask, m_mask);
    check("R10 ref untouched", act_ref, snap);

    finish_run();
  end
endmodule